// File: doc/BRIEF.md
# Programmable Up-Counting Timer Channel

This block is one 28-bit timer channel behind a plain 32-bit register port: a word address, a write strobe, write data and combinational read data. When the channel is enabled, a clock divider produces one count step every N input clocks, and the count steps upward. Software programs an end value, called the limit. When the count reaches the limit, it returns to zero and the channel flags an event. If the count passes the top of its 28-bit range, it also returns to zero, but that wrap flags nothing.

Two run modes select what happens on a wrap. In repeat mode the channel keeps counting from zero, which gives a periodic tick source. In single mode the channel turns off its own enable bit, so it stops after one pass; software uses this for one-off delays. The event flag is sticky and is cleared by writing a one to it. An interrupt enable bit masks the level interrupt output. Software can write the count at any time, for example to preset it before enabling the channel.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous active-low reset, all four registers read 0 and `irq` is 0.
- R2: The limit sits at byte address 0x0, the count at 0x4, control at 0x8 and interrupt status at 0xC. Control holds enable in bit 28, mode in bit 24 and the divisor in bits [15:0]. Interrupt status holds enable in bit 20 and the sticky flag in bit 16. Limit and count use bits [27:0]. Every other bit reads 0. Any other address ignores writes and reads 0.
- R3: While the channel is enabled, the count rises by exactly one on each divider step and never changes between steps.
- R4: A divisor of 0 or 1 gives a step on every clock. A divisor D ≥ 2 gives one step every D clocks. The divider phase restarts on every control write and while the channel is disabled.
- R5: With a nonzero limit L, the step that would make the count equal L instead sets it to 0 and sets the sticky flag, so one period is L steps.
- R6: A step taken at count 0x0FFFFFFF sets the count to 0 without setting the flag. A limit of 0 disables the compare, so only this wrap applies.
- R7: Single mode (control bit 24 = 0): on any wrap the enable bit clears by itself, and the count then stays at 0.
- R8: Repeat mode (control bit 24 = 1): the enable bit stays set on a wrap, and counting continues from 0.
- R9: A control write with bit 28 = 0 stops counting, and the count holds its value.
- R10: A count write loads bits [27:0]. It wins over a step in the same cycle.
- R11: Writing 1 to interrupt-status bit 16 clears the flag, and writing 0 there leaves it unchanged. A limit match in the same cycle as a clear leaves the flag set.
- R12: `irq` is high exactly when both the flag and the interrupt enable are set. It follows them in the cycle after the edge that changes them.
- R13: If a control write lands in the same cycle as a single-mode wrap, the written enable value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
Every piece of state in this block can be read back through the register port, so a wrong value shows up at the next read. The bench's reference model therefore compares the read data for the address on the bus, and the `irq` level, on every clock. A divider phase that is off by one stays hidden until the next step, so it shows up within D clocks as a count that changes one cycle early or late. A wrong wrap decision shows up within one step as a count above the limit, a missing flag, or an enable bit that fails to clear (or clears when it should not).

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
// Package for the timer channel: default sizes, register byte offsets,
// field bit positions and the run-mode type.
// Assumes a 32-bit register bus addressed in bytes with word-aligned registers.
package tick_timer_pkg;
    localparam int CNT_W  = 28;
    localparam int DIV_W  = 16;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;

    // byte offsets of the four registers
    localparam int OFS_LIMIT = 'h0;
    localparam int OFS_COUNT = 'h4;
    localparam int OFS_CTRL  = 'h8;
    localparam int OFS_ISTAT = 'hC;

    // field positions
    localparam int CTRL_EN_BIT   = 28;
    localparam int CTRL_MODE_BIT = 24;
    localparam int IST_EN_BIT    = 20;
    localparam int IST_FLAG_BIT  = 16;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_REPEAT = 1'b1
    } run_mode_e;
endpackage

// File: rtl/tick_prescaler.sv
`timescale 1ns/1ps
// Clock divider: produces a one-cycle step strobe every DIV clocks
// while the channel runs.
// Assumes DIV values 0 and 1 both mean "step every clock". The phase is
// cleared while stopped and on a control write (restart).
module tick_prescaler #(
    parameter int DIV_W = tick_timer_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             step
);
    logic [DIV_W-1:0] phase;
    logic             divided;

    // divisor of two or more uses the phase counter
    assign divided = (div > DIV_W'(1));
    // step strobe: every clock when undivided, else on the last phase
    assign step    = run && (!divided || (phase == div - DIV_W'(1)));

    // phase counter: counts clocks between steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!run || restart || step) begin
            phase <= '0;
        end else begin
            phase <= phase + DIV_W'(1);
        end
    end
endmodule

// File: rtl/tick_core.sv
`timescale 1ns/1ps
// Count register with limit compare and natural wrap detection.
// Assumes limit 0 means "no compare". A software load wins over a step.
// hit/wrap are single-cycle strobes, valid in the cycle of the step.
module tick_core #(
    parameter int CNT_W = tick_timer_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             hit,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] next_val;
    logic             at_top;
    logic             cmp_on;

    // candidate value after a step
    assign next_val = count + CNT_W'(1);
    // top of range reached: next step wraps naturally
    assign at_top   = (count == TOP);
    // compare active only for a nonzero limit
    assign cmp_on   = (limit != '0);
    // limit match on this step
    assign hit      = step && cmp_on && (next_val == limit);
    // any return to zero on this step
    assign wrap     = step && (hit || at_top);

    // count register: load, wrap to zero, or advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (wrap) begin
            count <= '0;
        end else if (step) begin
            count <= next_val;
        end
    end
endmodule

// File: rtl/tick_regs.sv
`timescale 1ns/1ps
// Register block: address decode, control/limit/interrupt registers and
// the read multiplexer.
// Assumes one-cycle write strobes. A software control write overrides the
// hardware enable clear; a limit match overrides a flag clear.
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = tick_timer_pkg::CNT_W,
    parameter int DIV_W  = tick_timer_pkg::DIV_W,
    parameter int BUS_W  = tick_timer_pkg::BUS_W,
    parameter int ADDR_W = tick_timer_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              hit,
    input  logic              wrap,
    output logic              run_en,
    output run_mode_e         run_mode,
    output logic [DIV_W-1:0]  run_div,
    output logic [CNT_W-1:0]  limit,
    output logic              ctl_wr,
    output logic              cnt_wr,
    output logic              flag,
    output logic              int_en
);
    localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(OFS_LIMIT);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_ISTAT = ADDR_W'(OFS_ISTAT);

    logic lim_wr;
    logic ist_wr;
    logic flag_clr;
    logic unused_wdata_hi;

    // write decode per register
    assign lim_wr   = bus_we && (bus_addr == A_LIMIT);
    assign cnt_wr   = bus_we && (bus_addr == A_COUNT);
    assign ctl_wr   = bus_we && (bus_addr == A_CTRL);
    assign ist_wr   = bus_we && (bus_addr == A_ISTAT);
    // write-one-to-clear request for the flag
    assign flag_clr = ist_wr && bus_wdata[IST_FLAG_BIT];
    // bits above the enable field are never stored
    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:CTRL_EN_BIT+1];

    // control register: software write, else self-clear on single-mode wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en   <= 1'b0;
            run_mode <= MODE_SINGLE;
            run_div  <= '0;
        end else if (ctl_wr) begin
            run_en   <= bus_wdata[CTRL_EN_BIT];
            run_mode <= run_mode_e'(bus_wdata[CTRL_MODE_BIT]);
            run_div  <= bus_wdata[DIV_W-1:0];
        end else if (wrap && (run_mode == MODE_SINGLE)) begin
            run_en   <= 1'b0;
        end
    end

    // limit register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit <= '0;
        end else if (lim_wr) begin
            limit <= bus_wdata[CNT_W-1:0];
        end
    end

    // interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_en <= 1'b0;
        end else if (ist_wr) begin
            int_en <= bus_wdata[IST_EN_BIT];
        end
    end

    // sticky flag: set by limit match, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

    // read multiplexer, unused bits zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_LIMIT: bus_rdata[CNT_W-1:0] = limit;
            A_COUNT: bus_rdata[CNT_W-1:0] = count;
            A_CTRL: begin
                bus_rdata[CTRL_EN_BIT]   = run_en;
                bus_rdata[CTRL_MODE_BIT] = run_mode;
                bus_rdata[DIV_W-1:0]     = run_div;
            end
            A_ISTAT: begin
                bus_rdata[IST_EN_BIT]   = int_en;
                bus_rdata[IST_FLAG_BIT] = flag;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
// Top of the timer channel: ties divider, count core and register block.
// Assumes the register port is driven synchronously to clk.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = tick_timer_pkg::CNT_W,
    parameter int DIV_W  = tick_timer_pkg::DIV_W,
    parameter int BUS_W  = tick_timer_pkg::BUS_W,
    parameter int ADDR_W = tick_timer_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    logic             run_en;
    run_mode_e        run_mode;
    logic [DIV_W-1:0] run_div;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] count;
    logic             step;
    logic             hit;
    logic             wrap;
    logic             ctl_wr;
    logic             cnt_wr;
    logic             flag;
    logic             int_en;

    tick_regs #(
        .CNT_W (CNT_W),
        .DIV_W (DIV_W),
        .BUS_W (BUS_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .count    (count),
        .hit      (hit),
        .wrap     (wrap),
        .run_en   (run_en),
        .run_mode (run_mode),
        .run_div  (run_div),
        .limit    (limit),
        .ctl_wr   (ctl_wr),
        .cnt_wr   (cnt_wr),
        .flag     (flag),
        .int_en   (int_en)
    );

    tick_prescaler #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_en),
        .restart(ctl_wr),
        .div    (run_div),
        .step   (step)
    );

    tick_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .load    (cnt_wr),
        .load_val(bus_wdata[CNT_W-1:0]),
        .limit   (limit),
        .count   (count),
        .hit     (hit),
        .wrap    (wrap)
    );

    // interrupt level: flag masked by enable
    assign irq = flag & int_en;
endmodule

// File: rtl/tick_timer_chk.sv
`timescale 1ns/1ps
// Property checker for the timer channel, bound into tick_timer.
// Assumes it sees the internal strobes of the register block and core.
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = tick_timer_pkg::CNT_W,
    parameter int BUS_W  = tick_timer_pkg::BUS_W,
    parameter int ADDR_W = tick_timer_pkg::ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              run_en,
    input run_mode_e         run_mode,
    input logic              step,
    input logic              hit,
    input logic              wrap,
    input logic [CNT_W-1:0]  count,
    input logic              flag,
    input logic              ctl_wr,
    input logic              cnt_wr
);
    logic ist_clr;
    // software request to clear the flag, decoded from the port
    assign ist_clr = bus_we && (bus_addr == ADDR_W'(OFS_ISTAT)) && bus_wdata[IST_FLAG_BIT];

    // R4: a step only occurs while enabled
    assert_step_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> run_en);

    // R5: the flag only rises after a limit match
    assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(hit));

    // R7: single mode drops enable after a wrap
    assert_single_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && (run_mode == MODE_SINGLE) && !ctl_wr) |=> !run_en);

    // R8: repeat mode keeps enable after a wrap
    assert_repeat_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && (run_mode == MODE_REPEAT) && !ctl_wr) |=> run_en);

    // R9: no count change while disabled and not loaded
    assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !cnt_wr) |=> $stable(count));

    // R11: the flag stays set unless cleared by software
    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ist_clr) |=> flag);

    // R13: a control write sets the enable to the written value
    assert_ctl_write_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (run_en == $past(bus_wdata[CTRL_EN_BIT])));
endmodule

bind tick_timer tick_timer_chk #(
    .CNT_W (CNT_W),
    .BUS_W (BUS_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .run_en   (run_en),
    .run_mode (run_mode),
    .step     (step),
    .hit      (hit),
    .wrap     (wrap),
    .count    (count),
    .flag     (flag),
    .ctl_wr   (ctl_wr),
    .cnt_wr   (cnt_wr)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
// Bench for tick_timer: behavioural reference model compared every clock,
// plus directed checks with hand-derived values.
module tick_timer_tb;
    localparam longint MASK = 64'h0FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // reference model state
    longint m_lim, m_cnt;
    int     m_div, m_pre;
    bit     m_en, m_mode, m_ie, m_flag;

    tick_timer u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [3:0] a);
        logic [31:0] v;
        v = 32'h0;
        case (a)
            4'h0: v = 32'(m_lim);
            4'h4: v = 32'(m_cnt);
            4'h8: v = {3'b0, m_en, 3'b0, m_mode, 8'h0, 16'(m_div)};
            4'hC: v = {11'b0, m_ie, 3'b0, m_flag, 16'h0};
            default: v = 32'h0;
        endcase
        return v;
    endfunction

    // reference model: one update per rising edge
    always @(posedge clk) begin
        bit     st, hit, wrp;
        longint nc;
        started = 1'b1;
        if (!rst_n) begin
            m_lim = 0; m_cnt = 0; m_div = 0; m_pre = 0;
            m_en = 0; m_mode = 0; m_ie = 0; m_flag = 0;
        end else begin
            st  = m_en && (m_div <= 1 || m_pre == m_div - 1);
            hit = 0; wrp = 0; nc = m_cnt;
            if (st) begin
                if (m_lim != 0 && ((m_cnt + 1) & MASK) == m_lim) begin
                    hit = 1; wrp = 1; nc = 0;
                end else if (m_cnt == MASK) begin
                    wrp = 1; nc = 0;
                end else begin
                    nc = m_cnt + 1;
                end
            end
            if (!m_en || st) m_pre = 0; else m_pre = m_pre + 1;
            if (wrp && !m_mode) m_en = 0;
            if (bus_we && bus_addr == 4'hC && bus_wdata[16]) m_flag = 0;
            if (hit) m_flag = 1;
            if (bus_we) begin
                case (bus_addr)
                    4'h0: m_lim = longint'(bus_wdata) & MASK;
                    4'h4: nc = longint'(bus_wdata) & MASK;
                    4'h8: begin
                        m_en = bus_wdata[28]; m_mode = bus_wdata[24];
                        m_div = int'(bus_wdata[15:0]); m_pre = 0;
                    end
                    4'hC: m_ie = bus_wdata[20];
                    default: ;
                endcase
            end
            m_cnt = nc;
        end
    end

    // per-cycle comparison of read data and interrupt against the model
    always @(negedge clk) begin
        #1;
        if (started && !done) begin
            check("R3 per-cycle readback", bus_rdata, model_read(bus_addr));
            check("R12 per-cycle irq", {31'b0, irq}, {31'b0, m_flag & m_ie});
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        check(req, bus_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [31:0] held;
        do_reset();
        // R1 reset values
        rd("R1 limit after reset", 4'h0, 32'h0);
        rd("R1 count after reset", 4'h4, 32'h0);
        rd("R1 ctrl after reset", 4'h8, 32'h0);
        rd("R1 istat after reset", 4'hC, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R2 field layout and unused bits
        wr(4'h0, 32'hFFFF_FFFF);
        rd("R2 limit upper bits zero", 4'h0, 32'h0FFF_FFFF);
        wr(4'h8, 32'hE7FF_1234);
        rd("R2 ctrl fields", 4'h8, 32'h0100_1234);
        wr(4'hC, 32'hFFEF_FFFF);
        rd("R2 istat fields", 4'hC, 32'h0);
        wr(4'h2, 32'h0000_0000);
        rd("R2 unmapped write ignored", 4'h0, 32'h0FFF_FFFF);
        rd("R2 unmapped read zero", 4'h6, 32'h0);
        wr(4'h4, 32'hF000_0123);
        rd("R10 count write", 4'h4, 32'h0000_0123);

        // R4 divide by four, repeat mode, no limit
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0);
        wr(4'h8, 32'h1100_0004);
        repeat (40) @(negedge clk);
        rd("R4 count after 41 clocks at div 4", 4'h4, 32'd10);

        // R9 disable holds count
        wr(4'h8, 32'h0);
        rd("R9 ctrl after disable", 4'h8, 32'h0);
        @(negedge clk);
        held = bus_rdata;
        bus_addr = 4'h4;
        #0.5 held = bus_rdata;
        repeat (5) @(negedge clk);
        rd("R9 count held while disabled", 4'h4, held);

        // R5 R8 repeat mode with limit 3
        wr(4'h4, 32'h0);
        wr(4'h0, 32'd3);
        wr(4'h8, 32'h1100_0001);
        repeat (10) @(negedge clk);
        rd("R5 count cycles below limit", 4'h4, 32'd2);
        rd("R8 enable kept in repeat mode", 4'h8, 32'h1100_0001);
        rd("R5 flag set by limit", 4'hC, 32'h0001_0000);
        check("R12 irq masked when disabled", {31'b0, irq}, 32'h0);

        // R7 single mode stops
        wr(4'h8, 32'h0);
        wr(4'hC, 32'h0001_0000);
        wr(4'h4, 32'h0);
        wr(4'h0, 32'd5);
        wr(4'h8, 32'h1000_0001);
        repeat (10) @(negedge clk);
        rd("R7 count stays zero", 4'h4, 32'h0);
        rd("R7 enable self-cleared", 4'h8, 32'h0000_0001);
        rd("R5 flag after single pass", 4'hC, 32'h0001_0000);
        wr(4'hC, 32'h0010_0000);
        rd("R11 writing zero keeps flag", 4'hC, 32'h0011_0000);
        check("R12 irq raised", {31'b0, irq}, 32'h1);
        wr(4'hC, 32'h0011_0000);
        rd("R11 writing one clears flag", 4'hC, 32'h0010_0000);
        check("R12 irq dropped", {31'b0, irq}, 32'h0);

        // R6 natural wrap, no flag
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0FFF_FFFE);
        wr(4'h8, 32'h1100_0001);
        rd("R6 count at top", 4'h4, 32'h0FFF_FFFF);
        rd("R6 count wrapped", 4'h4, 32'h0);
        rd("R6 no flag on natural wrap", 4'hC, 32'h0010_0000);
        wr(4'h8, 32'h0);
        wr(4'h4, 32'h0FFF_FFFE);
        wr(4'h8, 32'h1000_0000);
        repeat (4) @(negedge clk);
        rd("R7 single mode stops on natural wrap", 4'h8, 32'h0);
        rd("R4 div 0 steps every clock", 4'h4, 32'h0);

        // R10 load wins over step
        wr(4'h8, 32'h1100_0001);
        wr(4'h4, 32'h0000_0100);
        rd("R10 load then one step", 4'h4, 32'h0000_0101);

        // R13 control write coincides with single-mode wrap
        wr(4'h8, 32'h0);
        wr(4'hC, 32'h0011_0000);
        wr(4'h0, 32'd3);
        wr(4'h4, 32'h0);
        wr(4'h8, 32'h1000_0001);
        @(negedge clk);
        wr(4'h8, 32'h1000_0001);
        rd("R13 written enable kept", 4'h8, 32'h1000_0001);
        rd("R5 flag from coinciding wrap", 4'hC, 32'h0011_0000);
        check("R12 irq with flag and enable", {31'b0, irq}, 32'h1);

        // R1 reset in mid run
        do_reset();
        rd("R1 ctrl after second reset", 4'h8, 32'h0);
        rd("R1 istat after second reset", 4'hC, 32'h0);
        rd("R1 count after second reset", 4'h4, 32'h0);
        check("R1 irq after second reset", {31'b0, irq}, 32'h0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule